// File: doc/BRIEF.md
# Oscilloscope Front-End Control Unit

This block turns byte-wide vendor commands, each carrying a one-byte argument, into the control state of a two-channel sampling front end. It keeps an 8-bit range-select word that holds one 3-bit gain field per channel. It also keeps a sample-rate code and a channel count for the capture engine, and it issues one-cycle start and stop requests to that engine.

Every accepted command first requests a stop. It then lights a red status LED for a fixed number of millisecond ticks. A start command instead lights the green LED and leaves it lit with no time limit. A free-running prescaler derives a half-millisecond tick from the system clock. That tick toggles a calibration output, which gives a 1 kHz square wave, and every second tick drives the LED countdown.

Commands arrive as single-cycle strobes. All outputs are registered, so a command presented at clock edge N becomes visible after edge N.

Top module: `fe_ctrl`

## Requirements
- R1: After reset: range_o = 0x48 (gain argument 1 on both channels), rate_o = 1, nchan_o = 2, both LED outputs 1 (unlit), cal_o = 0, and cap_stop_o, cap_start_o and unhandled_o all 0.
- R2: A gain argument maps to a 3-bit code: 1 gives 010, 2 gives 001, 5 gives 000 and 10 gives 011, so bit 2 of the code is always 0. Any other argument leaves range_o unchanged.
- R3: Command 0xE0 writes channel 0's code into range_o[4:2]. Command 0xE1 writes channel 1's code into range_o[7:5]. All other bits of range_o keep their values, and range_o changes only on such a command.
- R4: Command 0xE2 stores its argument as rate_o, and rate_o changes only on that command.
- R5: Command 0xE4 stores its argument in nchan_o only when the argument is 1 or 2. Any other argument leaves nchan_o unchanged.
- R6: Every command, known or unknown, raises cap_stop_o for exactly the one cycle after it is accepted.
- R7: A command that is not a start lights the red LED (led_red_no = 0, led_grn_no = 1) and loads a countdown of LED_MS millisecond ticks. When the countdown reaches zero, both LED outputs go to 1. A countdown of zero means idle.
- R8: Command 0xE3 with argument 1 raises cap_start_o for one cycle, clears the countdown, and keeps the green LED lit (led_grn_no = 0, led_red_no = 1) until the next command. Command 0xE3 with any other argument acts like any other non-start command.
- R9: cal_o toggles once every TICK_DIV clock cycles, with the first toggle at the TICK_DIV-th edge after reset.
- R10: A command code outside 0xE0 to 0xE4 raises unhandled_o for one cycle, in the same cycle as its stop request.
- R11: The LED countdown moves down by one on every second half-millisecond tick. A command in the same cycle as a tick takes priority over the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_code_i | input | 8 | Command code |
| cmd_arg_i | input | 8 | Command argument |
| range_o | output | 8 | Range-select word, one gain field per channel |
| rate_o | output | 8 | Selected sample-rate code |
| nchan_o | output | 2 | Active channel count (1 or 2) |
| cap_stop_o | output | 1 | Stop request pulse to the capture engine |
| cap_start_o | output | 1 | Start request pulse to the capture engine |
| unhandled_o | output | 1 | Pulse for an unknown command code |
| led_red_no | output | 1 | Red LED, active low |
| led_grn_no | output | 1 | Green LED, active low |
| cal_o | output | 1 | Calibration square wave |

## Verification
The bench builds the block with TICK_DIV = 4 and LED_MS = 5. The millisecond tick therefore comes every 8 cycles, and a red indication expires after about 40 cycles. This brings within reach the expiry of the red LED, a green LED that outlives many tick periods, a command landing on a tick edge, and back-to-back commands that reload the countdown. Each of these is compared cycle by cycle against a behavioural model that uses integers.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam logic [7:0] CMD_GAIN0 = 8'hE0;
  localparam logic [7:0] CMD_GAIN1 = 8'hE1;
  localparam logic [7:0] CMD_RATE  = 8'hE2;
  localparam logic [7:0] CMD_START = 8'hE3;
  localparam logic [7:0] CMD_NCH   = 8'hE4;

  localparam int NUM_CH   = 2;
  localparam int FIELD_W  = 3;
  localparam int FIELD_LO = 2;

  typedef enum logic [1:0] {LED_OFF, LED_RED, LED_GRN} led_e;

  // {valid, code}
  function automatic logic [3:0] gain_enc(input logic [7:0] arg);
    case (arg)
      8'd1:    gain_enc = 4'b1010;
      8'd2:    gain_enc = 4'b1001;
      8'd5:    gain_enc = 4'b1000;
      8'd10:   gain_enc = 4'b1011;
      default: gain_enc = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/fe_tick.sv
module fe_tick #(
  parameter int TICK_DIV = 62500
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ms_tick_o,
  output logic cal_o
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic          half_tick;

  assign half_tick = (cnt_q == LAST);
  assign ms_tick_o = half_tick & phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      cal_o   <= 1'b0;
    end else if (half_tick) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
      cal_o   <= ~cal_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9
  cal_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_tick |=> (cal_o != $past(cal_o)));
  // R9
  cal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_tick |=> $stable(cal_o));
endmodule

// File: rtl/fe_decode.sv
module fe_decode
  import fe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_code_i,
  input  logic [7:0] cmd_arg_i,
  output logic       start_req_o,
  output logic [7:0] range_o,
  output logic [7:0] rate_o,
  output logic [1:0] nchan_o,
  output logic       stop_o,
  output logic       start_o,
  output logic       unh_o
);
  localparam logic [7:0] RANGE_RST = 8'h48;

  logic [3:0] gc;
  logic [7:0] range_d;
  logic       known;

  assign gc          = gain_enc(cmd_arg_i);
  assign known       = (cmd_code_i >= CMD_GAIN0) && (cmd_code_i <= CMD_NCH);
  assign start_req_o = cmd_valid_i && (cmd_code_i == CMD_START) && (cmd_arg_i == 8'd1);

  always_comb begin
    range_d = range_o;
    for (int c = 0; c < NUM_CH; c++) begin
      if (cmd_valid_i && gc[3] && (cmd_code_i == CMD_GAIN0 + 8'(c)))
        range_d[FIELD_LO + c*FIELD_W +: FIELD_W] = gc[2:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      range_o <= RANGE_RST;
      rate_o  <= 8'd1;
      nchan_o <= 2'd2;
      stop_o  <= 1'b0;
      start_o <= 1'b0;
      unh_o   <= 1'b0;
    end else begin
      range_o <= range_d;
      stop_o  <= cmd_valid_i;
      start_o <= start_req_o;
      unh_o   <= cmd_valid_i && !known;
      if (cmd_valid_i && cmd_code_i == CMD_RATE)
        rate_o <= cmd_arg_i;
      if (cmd_valid_i && cmd_code_i == CMD_NCH &&
          (cmd_arg_i == 8'd1 || cmd_arg_i == 8'd2))
        nchan_o <= cmd_arg_i[1:0];
    end
  end

  // R6
  stop_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> stop_o);
  // R10
  unh_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unh_o |-> stop_o);
  // R5
  nchan_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nchan_o == 2'd1) || (nchan_o == 2'd2));
  // R2
  gain_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !range_o[4] && !range_o[7]);
  // R3
  range_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(range_o) && range_o[1:0] == 2'b00);
  // R4
  rate_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(rate_o));
endmodule

// File: rtl/fe_led.sv
module fe_led
  import fe_pkg::*;
#(
  parameter int LED_MS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic start_req_i,
  input  logic ms_tick_i,
  output logic led_red_no,
  output logic led_grn_no
);
  localparam int LW = $clog2(LED_MS + 1);
  localparam logic [LW-1:0] LOAD = LW'(LED_MS);

  led_e          st_q;
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= LED_OFF;
      cnt_q <= '0;
    end else if (cmd_valid_i) begin
      if (start_req_i) begin
        st_q  <= LED_GRN;
        cnt_q <= '0;
      end else begin
        st_q  <= LED_RED;
        cnt_q <= LOAD;
      end
    end else if (ms_tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == LW'(1)) st_q <= LED_OFF;
    end
  end

  assign led_red_no = (st_q != LED_RED);
  assign led_grn_no = (st_q != LED_GRN);

  // R8
  grn_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_i |=> (!led_grn_no && led_red_no));
  // R7
  red_after_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !start_req_i) |=> (!led_red_no && led_grn_no));
  // R7
  red_timed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_q == LED_RED && cnt_q == '0));
  // R8
  grn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!led_grn_no && !cmd_valid_i) |=> !led_grn_no);
endmodule

// File: rtl/fe_ctrl.sv
module fe_ctrl #(
  parameter int TICK_DIV = 62500,
  parameter int LED_MS   = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_code_i,
  input  logic [7:0] cmd_arg_i,
  output logic [7:0] range_o,
  output logic [7:0] rate_o,
  output logic [1:0] nchan_o,
  output logic       cap_stop_o,
  output logic       cap_start_o,
  output logic       unhandled_o,
  output logic       led_red_no,
  output logic       led_grn_no,
  output logic       cal_o
);
  logic ms_tick;
  logic start_req;

  fe_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ms_tick_o (ms_tick),
    .cal_o     (cal_o)
  );

  fe_decode u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_code_i  (cmd_code_i),
    .cmd_arg_i   (cmd_arg_i),
    .start_req_o (start_req),
    .range_o     (range_o),
    .rate_o      (rate_o),
    .nchan_o     (nchan_o),
    .stop_o      (cap_stop_o),
    .start_o     (cap_start_o),
    .unh_o       (unhandled_o)
  );

  fe_led #(.LED_MS(LED_MS)) u_led (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .start_req_i (start_req),
    .ms_tick_i   (ms_tick),
    .led_red_no  (led_red_no),
    .led_grn_no  (led_grn_no)
  );
endmodule

// File: tb/sim_fe_ctrl.sv
module sim_fe_ctrl;
  localparam int DIV = 4;
  localparam int LMS = 5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [7:0] cmd_code_i = 8'h00;
  logic [7:0] cmd_arg_i = 8'h00;
  logic [7:0] range_o, rate_o;
  logic [1:0] nchan_o;
  logic       cap_stop_o, cap_start_o, unhandled_o, led_red_no, led_grn_no, cal_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural model state
  int m_range = 'h48, m_rate = 1, m_nch = 2;
  int m_stop = 0, m_start = 0, m_unh = 0, m_cal = 0;
  int m_led = 0;  // 0 off, 1 red, 2 green
  int m_cnt = 0, m_pre = 0, m_phase = 0;

  always #4 clk = ~clk;

  fe_ctrl #(.TICK_DIV(DIV), .LED_MS(LMS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
    .cmd_code_i(cmd_code_i), .cmd_arg_i(cmd_arg_i), .range_o(range_o),
    .rate_o(rate_o), .nchan_o(nchan_o), .cap_stop_o(cap_stop_o),
    .cap_start_o(cap_start_o), .unhandled_o(unhandled_o),
    .led_red_no(led_red_no), .led_grn_no(led_grn_no), .cal_o(cal_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int enc(input int a);
    case (a)
      1: return 2;
      2: return 1;
      5: return 0;
      10: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic model_edge(input int v, input int code, input int arg);
    bit tick, ms;
    int g;
    tick = (m_pre == DIV - 1);
    ms = tick && (m_phase == 1);
    m_pre = tick ? 0 : m_pre + 1;
    if (tick) begin m_phase ^= 1; m_cal ^= 1; end
    m_stop = v; m_start = 0; m_unh = 0;
    if (v) begin
      m_unh = (code < 'hE0 || code > 'hE4) ? 1 : 0;
      g = enc(arg);
      if (code == 'hE0 && g >= 0) m_range = (m_range & ~('h1C)) | (g << 2);
      if (code == 'hE1 && g >= 0) m_range = (m_range & ~('hE0)) | (g << 5);
      if (code == 'hE2) m_rate = arg;
      if (code == 'hE4 && (arg == 1 || arg == 2)) m_nch = arg;
      if (code == 'hE3 && arg == 1) begin m_start = 1; m_led = 2; m_cnt = 0; end
      else begin m_led = 1; m_cnt = LMS; end
    end else if (ms && m_cnt != 0) begin
      m_cnt--;
      if (m_cnt == 0) m_led = 0;
    end
  endtask

  task automatic compare_all();
    chk("R2/R3 range", range_o, m_range);
    chk("R4 rate", rate_o, m_rate);
    chk("R5 nchan", nchan_o, m_nch);
    chk("R6 stop", cap_stop_o, m_stop);
    chk("R8 start", cap_start_o, m_start);
    chk("R10 unhandled", unhandled_o, m_unh);
    chk("R7/R11 red", led_red_no, (m_led == 1) ? 0 : 1);
    chk("R8/R11 green", led_grn_no, (m_led == 2) ? 0 : 1);
    chk("R9 cal", cal_o, m_cal);
  endtask

  // called at a negedge; returns at the next negedge
  task automatic cyc(input int v, input int code, input int arg);
    cmd_valid_i = v[0];
    cmd_code_i  = code[7:0];
    cmd_arg_i   = arg[7:0];
    @(posedge clk);
    model_edge(v, code, arg);
    @(negedge clk);
    cmd_valid_i = 1'b0;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  task automatic cmd(input int code, input int arg);
    cyc(1, code, arg);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 range", range_o, 'h48);
    chk("R1 rate", rate_o, 1);
    chk("R1 nchan", nchan_o, 2);
    chk("R1 leds", {led_red_no, led_grn_no}, 3);
    chk("R1 cal", cal_o, 0);
    chk("R1 pulses", {cap_stop_o, cap_start_o, unhandled_o}, 0);
    rst_ni = 1'b1;
    idle(10);                      // R9 cal toggling
    cmd('hE0, 2); cmd('hE0, 5);    // R2 R3
    cmd('hE0, 10); idle(2);
    cmd('hE0, 3); cmd('hE0, 0);    // R2 rejected
    cmd('hE1, 10); cmd('hE1, 5);
    cmd('hE1, 7); cmd('hE1, 1);
    cmd('hE2, 'h37); cmd('hE2, 0); // R4
    cmd('hE4, 1); cmd('hE4, 3);    // R5
    cmd('hE4, 0); cmd('hE4, 2);
    cmd('h12, 0); cmd('hE5, 1);    // R10
    cmd('hFF, 1); cmd('hDF, 1);
    idle(60);                      // R7 expiry
    cmd('hE3, 0); idle(3);         // R8 non-start
    cmd('hE3, 1); idle(70);        // R8 green holds
    cmd('hE1, 2); idle(20);        // R11 reload mid-count
    cmd('hE0, 1); idle(50);
    for (int k = 0; k < 16; k++) begin  // R11 commands at every tick phase
      cmd('hE2, k); idle(k);
    end
    cmd('hE3, 1); cmd('hE0, 2); idle(60);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule